// File: doc/BRIEF.md
# Index-Data Configuration Register Port

This block is the byte-wide configuration window of a multi-function I/O chip. It sits on two adjacent addresses of a simple 8-bit bus. A write to the even address chooses a register number. A read or write at the odd address then reaches that register. Three configuration registers live behind the window: a function enable byte, a function address byte and a power/test byte. All three bytes drive the decode logic downstream at all times.

After reset, the first read of the even address returns a fixed identification byte. Software uses it to find the chip. From then on the even address reads back the selected register number.

The reset contents of the three registers come from a 32-entry default table. A 5-bit strap input picks the entry. A one-cycle pulse marks every accepted register write, so downstream logic knows when to re-decode its settings.

Top module: `cfg_index_port`

## Requirements
- R1: A write with `addr_i`=0 stores the full byte as the selected index. Once the identification byte has been returned, a read with `addr_i`=0 returns the selected index.
- R2: The first read with `addr_i`=0 after reset returns 0x88. Each index read moves the identification step on by exactly one, so every later index read returns the selected index.
- R3: A write with `addr_i`=0 also ends the identification step. An index read that follows such a write returns the index, not 0x88.
- R4: A write with `addr_i`=1 updates the selected register when the selected index is 0 (enable, `fen_o`), 1 (address, `fadr_o`) or 2 (power/test, `ptst_o`). The new value shows on that output after the write edge.
- R5: A write with `addr_i`=1 has no effect on any register when the selected index is 3 or more.
- R6: A read with `addr_i`=1 returns 0x00 when the selected index is 3 or more. For index 0 to 2 it returns that register.
- R7: While `rst_ni` is low, the selected index is 0, the identification step is cleared, and the registers take the strap defaults. Enable/address/power-test values are: strap 0 gives 0x4F/0x10/0x00, strap 1 gives 0x4F/0x11/0x00, strap 12 gives 0x0F/0x10/0x00, and strap 31 gives 0x00/0x10/0x02.
- R8: `cfg_upd_o` is high for exactly the one cycle after each data write that lands in a register. It stays low for discarded writes.
- R9: `rdata_o` is registered. It is valid from the clock edge that samples `rd_i` and holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | 5 | Default-table select, used while reset is held |
| addr_i | input | 1 | 0 = index port, 1 = data port |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| fen_o | output | 8 | Function enable register |
| fadr_o | output | 8 | Function address register |
| ptst_o | output | 8 | Power/test register |
| cfg_upd_o | output | 1 | One-cycle pulse after an accepted register write |

## Verification
The bench builds the block with its default parameters: three registers and identification byte 0x88. With these values, index bytes 3 and up are reachable as out-of-range selections, and the identification handoff can be seen on both the read path and the write path. Random index values are biased toward 0 to 4, so both in-range and discarded accesses occur often. Several strap settings are applied across repeated resets.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int DW      = 8;
  localparam int NREG    = 3;
  localparam int STRAP_W = 5;
  typedef logic [DW-1:0] byte_t;
  typedef logic [NREG-1:0][DW-1:0] regvec_t;
endpackage

// File: rtl/cfg_strap_rom.sv
module cfg_strap_rom
  import cfg_port_pkg::*;
(
  input  logic [STRAP_W-1:0] strap_i,
  output byte_t              fen_o,
  output byte_t              fadr_o,
  output byte_t              ptst_o
);
  always_comb begin
    case (strap_i) inside
      [5'd0:5'd5]:   fen_o = 8'h4F;
      [5'd6:5'd11]:  fen_o = 8'h4B;
      [5'd12:5'd15]: fen_o = 8'h0F;
      [5'd16:5'd19]: fen_o = 8'h49;
      [5'd20:5'd23]: fen_o = 8'h07;
      [5'd24:5'd29]: fen_o = 8'h47;
      5'd30:         fen_o = 8'h08;
      default:       fen_o = 8'h00;
    endcase
  end

  always_comb begin
    case (strap_i)
      5'd0, 5'd12, 5'd20, 5'd24, 5'd30, 5'd31: fadr_o = 8'h10;
      5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26:  fadr_o = 8'h11;
      5'd3, 5'd14, 5'd22, 5'd27:               fadr_o = 8'h39;
      5'd4, 5'd15, 5'd23, 5'd28:               fadr_o = 8'h24;
      5'd5, 5'd29:                             fadr_o = 8'h38;
      5'd7, 5'd8, 5'd17, 5'd18:                fadr_o = 8'h01;
      5'd9:                                    fadr_o = 8'h09;
      5'd10, 5'd11:                            fadr_o = 8'h08;
      default:                                 fadr_o = 8'h00;
    endcase
  end

  assign ptst_o = (strap_i == 5'd31) ? 8'h02 : 8'h00;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_port_pkg::*;
#(
  parameter int NR = NREG
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NR-1:0][DW-1:0]  rst_val_i,
  input  logic                   we_i,
  input  byte_t                  sel_i,
  input  byte_t                  wdata_i,
  output logic [NR-1:0][DW-1:0]  regs_o
);
  for (genvar g = 0; g < NR; g++) begin : g_reg
    logic hit;
    assign hit = we_i && (sel_i == DW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs_o[g] <= rst_val_i[g];
      else if (hit) regs_o[g] <= wdata_i;
    end

    // R5
    reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && sel_i == DW'(g)) |=> $stable(regs_o[g]));
    // R4
    reg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && sel_i == DW'(g)) |=> regs_o[g] == $past(wdata_i));
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_port_pkg::*;
#(
  parameter logic [7:0] ID_VAL = 8'h88
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic [7:0]         fen_o,
  output logic [7:0]         fadr_o,
  output logic [7:0]         ptst_o,
  output logic               cfg_upd_o
);
  localparam byte_t LIM = byte_t'(NREG);

  byte_t   def_fen, def_fadr, def_ptst;
  regvec_t rst_vec, regs;
  byte_t   idx_q, rdata_q, rd_mux;
  logic    id_done_q, upd_q;
  logic    idx_ok, data_wr, idx_wr, idx_rd, data_rd;

  cfg_strap_rom u_rom (
    .strap_i (strap_i),
    .fen_o   (def_fen),
    .fadr_o  (def_fadr),
    .ptst_o  (def_ptst)
  );

  assign rst_vec = {def_ptst, def_fadr, def_fen};
  assign idx_ok  = idx_q < LIM;
  assign data_wr = wr_i && addr_i;
  assign idx_wr  = wr_i && !addr_i;
  assign idx_rd  = rd_i && !addr_i;
  assign data_rd = rd_i && addr_i;

  cfg_regfile #(.NR(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_val_i (rst_vec),
    .we_i      (data_wr),
    .sel_i     (idx_q),
    .wdata_i   (wdata_i),
    .regs_o    (regs)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (idx_q == byte_t'(i)) rd_mux = regs[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      id_done_q <= 1'b0;
      rdata_q   <= '0;
      upd_q     <= 1'b0;
    end else begin
      upd_q <= data_wr && idx_ok;
      if (idx_wr) idx_q <= wdata_i;
      if (idx_wr || idx_rd) id_done_q <= 1'b1;
      if (idx_rd)       rdata_q <= id_done_q ? idx_q : ID_VAL;
      else if (data_rd) rdata_q <= rd_mux;
    end
  end

  assign rdata_o   = rdata_q;
  assign fen_o     = regs[0];
  assign fadr_o    = regs[1];
  assign ptst_o    = regs[2];
  assign cfg_upd_o = upd_q;

  // R2
  id_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_rd && !id_done_q) |=> rdata_o == ID_VAL);
  // R1
  idx_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_rd && id_done_q) |=> rdata_o == $past(idx_q));
  // R6
  bad_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !idx_ok) |=> rdata_o == 8'h00);
  // R8
  upd_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_upd_o) |-> $past(data_wr && idx_ok));
  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/tb_cfg_index_port.sv
module tb_cfg_index_port;
  localparam int CLK_P = 10;

  logic       clk_i = 0, rst_ni = 0;
  logic [4:0] strap_i = '0;
  logic       addr_i = 0, wr_i = 0, rd_i = 0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, fen_o, fadr_o, ptst_o;
  logic       cfg_upd_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_idx, m_rd;
  logic [7:0] m_reg [3];
  bit m_id;
  bit done = 0;

  cfg_index_port dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic chk_outs(string r);
    chk(r, fen_o, m_reg[0]);
    chk(r, fadr_o, m_reg[1]);
    chk(r, ptst_o, m_reg[2]);
  endtask

  task automatic do_reset(logic [4:0] s, logic [7:0] f, logic [7:0] a, logic [7:0] p);
    @(negedge clk_i);
    rst_ni = 0; strap_i = s;
    repeat (2) @(negedge clk_i);
    m_idx = 0; m_id = 0; m_rd = 0;
    m_reg[0] = f; m_reg[1] = a; m_reg[2] = p;
    chk("R7", rdata_o, 8'h00);
    chk_outs("R7");
    rst_ni = 1;
    strap_i = ~s;  // straps ignored after reset
    @(negedge clk_i);
    chk_outs("R7");
    chk("R8", cfg_upd_o, 0);
  endtask

  task automatic bwr(logic a, logic [7:0] d);
    bit hit;
    addr_i = a; wdata_i = d; wr_i = 1;
    @(negedge clk_i);
    wr_i = 0;
    hit = 0;
    if (!a) begin m_idx = d; m_id = 1; end
    else if (m_idx < 3) begin m_reg[m_idx] = d; hit = 1; end
    chk(a ? (hit ? "R4" : "R5") : "R3", fen_o, m_reg[0]);
    chk_outs(a ? (hit ? "R4" : "R5") : "R1");
    chk("R8", cfg_upd_o, hit);
    chk("R9", rdata_o, m_rd);
    @(negedge clk_i);
    chk("R8", cfg_upd_o, 0);
  endtask

  task automatic brd(logic a);
    string r;
    addr_i = a; rd_i = 1;
    @(negedge clk_i);
    rd_i = 0;
    if (!a) begin
      r = m_id ? "R1" : "R2";
      m_rd = m_id ? m_idx : 8'h88;
      m_id = 1;
    end else begin
      r = (m_idx < 3) ? "R9" : "R6";
      m_rd = (m_idx < 3) ? m_reg[m_idx] : 8'h00;
    end
    chk(r, rdata_o, m_rd);
    chk("R8", cfg_upd_o, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset(5'd1, 8'h4F, 8'h11, 8'h00);
    brd(0);                 // R2 id byte
    brd(0);                 // R1 index 0
    brd(1);                 // enable via data port
    bwr(1, 8'hA5);          // R4 enable
    bwr(0, 8'd2); bwr(1, 8'h3C); brd(1);
    bwr(0, 8'd5);
    bwr(1, 8'hFF);          // R5 discarded
    brd(1);                 // R6 zero
    brd(0);                 // R1 index 5
    do_reset(5'd31, 8'h00, 8'h10, 8'h02);
    bwr(0, 8'd1);           // R3 ends id step
    brd(0);
    bwr(1, 8'h77); brd(1);
    do_reset(5'd0, 8'h4F, 8'h10, 8'h00);
    bwr(0, 8'd3); bwr(1, 8'h12); brd(1); brd(0);
    do_reset(5'd12, 8'h0F, 8'h10, 8'h00);
    brd(1); brd(0); brd(0);
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 3);
      logic [7:0] d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 4));
      case (op)
        0: bwr(0, d);
        1: bwr(1, 8'($urandom));
        2: brd(0);
        default: brd(1);
      endcase
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule